// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block is the time-keeping core of a clock/calendar device. A single step input, pulsed once per hundredth of a second, advances a chain of BCD counters. The chain runs through hundredths, seconds, minutes, hours, a packed year/date byte and a packed weekday/month byte, which sit at register addresses 1 through 6. The hour byte selects 12-hour or 24-hour counting. The date counter follows month lengths and a four-year leap cycle that is driven by a 2-bit year field.

The register-access side can load any counter byte. A freeze input halts all stepping so that a new time can be loaded without a carry landing mid-load. A mask input hides the year and weekday fields when the packed bytes are read. In pulse-counting mode the first three bytes form a six-digit BCD counter that advances once per step pulse, and the hour and calendar bytes hold their values.

Top module: `ccc_top`

## Requirements
- R1: In time mode, address 1 counts BCD 00..99 and addresses 2 and 3 count BCD 00..59. Each byte wraps to 00 and steps the next byte in the same cycle that it wraps.
- R2: When hour bit 7 is 0 (24-hour format), hour bits 5:0 count BCD 00..23, and bit 6 is kept as written. The step from 23 to 00 advances the calendar by one day.
- R3: When hour bit 7 is 1 (12-hour format), bit 6 is the afternoon flag and bits 5:0 hold 01..12. The hour runs 12, 01 .. 11 with flag 0, then 12, 01 .. 11 with flag 1. The 11 to 12 step toggles the flag, and the step from 11 with flag 1 advances the calendar by one day.
- R4: Address 5 holds the year in bits 7:6 and the BCD date in bits 5:0. The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. This wrap steps the month.
- R5: In month 02 the date wraps after 29 when the year field is 0, and after 28 otherwise.
- R6: Address 6 holds the weekday in bits 7:5 and the BCD month in bits 4:0. The month wraps from 12 to 01 and then steps the year modulo 4. The weekday steps 0..6 and back to 0 on every day advance.
- R7: While halt_i is 1, no counter byte changes except through a write.
- R8: A write to address 1..6 appears on reads from the next cycle. It takes priority over a step to the same byte in the same cycle.
- R9: With mask_i set, reads of address 5 return only the date in bits 5:0 and reads of address 6 return only the month in bits 4:0. All other bits read as zero, and other addresses are not affected.
- R10: With evt_mode_i set, addresses 3:2:1 form a six-digit BCD counter with its least significant pair at address 1. Each step adds one, and 999999 wraps to 000000. Addresses 4..6 do not step.
- R11: Reset sets every counter byte to 00, which selects 24-hour format. Addresses other than 1..6 read 00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Step pulse, one per hundredth or per counted event |
| evt_mode_i | input | 1 | Six-digit pulse-counting mode |
| halt_i | input | 1 | Freeze all stepping |
| mask_i | input | 1 | Hide year and weekday fields on read |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data, combinational from the address |

## Verification
Every counter byte changes at the first clock edge after the step or write that affects it. Carries ripple through the whole chain within that one edge, so a step from 23:59:59.99 on the last day of a month updates all six bytes at once. The read path adds no delay: each byte is due on rd_data_o as soon as the address settles after that edge. The bench therefore updates its reference at each rising edge and then sweeps all eight read addresses before the next falling edge. Inputs change only at falling edges.

// File: rtl/ccc_pkg.sv
// Shared constants and BCD helpers for the clock-calendar counter chain.
// Assumes every counter value is packed BCD, two digits per byte.
package ccc_pkg;
    localparam int BYTE_W = 8;
    localparam int PAIRS  = 3;

    typedef logic [BYTE_W-1:0] bcd8_t;

    // Next BCD value of a two-digit pair (no wrap handling)
    function automatic bcd8_t bcd_next(input bcd8_t v);
        bcd8_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Last BCD date of a month given the 2-bit year
    function automatic logic [5:0] month_end(input logic [4:0] mon, input logic [1:0] yr);
        logic [5:0] r;
        case (mon)
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            5'h02:                      r = (yr == 2'd0) ? 6'h29 : 6'h28;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ccc_pair_cnt.sv
// Two-digit BCD counter stage with a wrap limit and a carry out.
// In time mode it wraps after CLK_LAST, and in pulse mode after 99.
// Assumes a write and a step can arrive together, and the write wins.
module ccc_pair_cnt
    import ccc_pkg::*;
#(
    parameter bcd8_t CLK_LAST = 8'h59
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_i,
    input  logic  evt_i,
    input  logic  wr_i,
    input  bcd8_t wdata_i,
    output bcd8_t value_o,
    output logic  carry_o
);
    bcd8_t value_q;
    bcd8_t lim;

    // Wrap limit depends on the counting mode
    always_comb lim = evt_i ? 8'h99 : CLK_LAST;

    assign carry_o = step_i && (value_q == lim);
    assign value_o = value_q;

    // Counter register: write has priority over a step
    always_ff @(posedge clk) begin
        if (!rst_n)      value_q <= '0;
        else if (wr_i)   value_q <= wdata_i;
        else if (step_i) value_q <= (value_q == lim) ? '0 : bcd_next(value_q);
    end

    // R1 / R10: a step at the limit lands on 00
    assert_pair_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i && value_q == lim) |=> (value_q == 8'h00));
    assert_pair_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (value_q == $past(wdata_i)));
    assert_pair_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !wr_i) |=> $stable(value_q));
endmodule

// File: rtl/ccc_hour_cnt.sv
// Hour register with format select in bit 7 and afternoon flag in bit 6.
// Counts 00..23 or 12,01..11 per half day and flags the day advance.
// Assumes legal BCD contents; illegal loads just keep incrementing.
module ccc_hour_cnt
    import ccc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_i,
    input  logic  wr_i,
    input  bcd8_t wdata_i,
    output bcd8_t value_o,
    output logic  carry_o
);
    bcd8_t      hour_q;
    bcd8_t      hour_nx;
    logic       day_wrap;
    logic [5:0] hr;
    bcd8_t      hr_inc;

    assign hr     = hour_q[5:0];
    assign hr_inc = bcd_next({2'b00, hr});

    // Next hour value and day-advance condition
    always_comb begin
        day_wrap = 1'b0;
        hour_nx  = {hour_q[7:6], hr_inc[5:0]};
        if (hour_q[7]) begin
            if (hr == 6'h11) begin
                hour_nx  = {1'b1, ~hour_q[6], 6'h12};
                day_wrap = hour_q[6];
            end else if (hr == 6'h12) begin
                hour_nx = {1'b1, hour_q[6], 6'h01};
            end
        end else if (hr == 6'h23) begin
            hour_nx  = {hour_q[7:6], 6'h00};
            day_wrap = 1'b1;
        end
    end

    assign carry_o = step_i && day_wrap;
    assign value_o = hour_q;

    // Hour register: write has priority over a step
    always_ff @(posedge clk) begin
        if (!rst_n)      hour_q <= '0;
        else if (wr_i)   hour_q <= wdata_i;
        else if (step_i) hour_q <= hour_nx;
    end

    assert_hour_24wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i && !hour_q[7] && hr == 6'h23) |=> (hour_q[5:0] == 6'h00));
    assert_hour_pmflip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i && hour_q[7] && hr == 6'h11) |=>
        (hour_q[6] != $past(hour_q[6]) && hour_q[5:0] == 6'h12));
    assert_hour_twelve_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i && hour_q[7] && hr == 6'h12) |=> (hour_q[5:0] == 6'h01 && $stable(hour_q[7:6])));
endmodule

// File: rtl/ccc_date_cnt.sv
// Calendar bytes: {year[1:0], date BCD} and {weekday[2:0], month BCD}.
// Applies month lengths and the year-0 leap February on each day advance.
// Assumes each byte can be written on its own, and a write beats a step.
module ccc_date_cnt
    import ccc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_i,
    input  logic  wr_date_i,
    input  logic  wr_month_i,
    input  bcd8_t wdata_i,
    output bcd8_t date_byte_o,
    output bcd8_t month_byte_o
);
    bcd8_t      date_q, month_q;
    bcd8_t      date_nx, month_nx;
    logic [1:0] yr;
    logic [5:0] day;
    logic [2:0] wd;
    logic [4:0] mon;
    logic       day_wrap, mon_wrap;
    bcd8_t      day_inc, mon_inc;

    assign yr      = date_q[7:6];
    assign day     = date_q[5:0];
    assign wd      = month_q[7:5];
    assign mon     = month_q[4:0];
    assign day_inc = bcd_next({2'b00, day});
    assign mon_inc = bcd_next({3'b000, mon});

    // Next values of both calendar bytes for one day advance
    always_comb begin
        day_wrap = (day == month_end(mon, yr));
        mon_wrap = day_wrap && (mon == 5'h12);
        date_nx  = day_wrap ? {mon_wrap ? yr + 2'd1 : yr, 6'h01} : {yr, day_inc[5:0]};
        month_nx = {(wd == 3'd6) ? 3'd0 : wd + 3'd1,
                    mon_wrap ? 5'h01 : (day_wrap ? mon_inc[4:0] : mon)};
    end

    // Year/date byte register
    always_ff @(posedge clk) begin
        if (!rst_n)         date_q <= '0;
        else if (wr_date_i) date_q <= wdata_i;
        else if (step_i)    date_q <= date_nx;
    end

    // Weekday/month byte register
    always_ff @(posedge clk) begin
        if (!rst_n)          month_q <= '0;
        else if (wr_month_i) month_q <= wdata_i;
        else if (step_i)     month_q <= month_nx;
    end

    assign date_byte_o  = date_q;
    assign month_byte_o = month_q;

    assert_date_leap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_date_i && !wr_month_i && mon == 5'h02 && day == 6'h28 && yr == 2'd0)
        |=> (date_q[5:0] == 6'h29));
    assert_date_feb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_date_i && !wr_month_i && mon == 5'h02 && day == 6'h28 && yr != 2'd0)
        |=> (date_q[5:0] == 6'h01 && month_q[4:0] == 5'h03));
    assert_month_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_date_i && !wr_month_i && mon == 5'h12 && day == 6'h31)
        |=> (month_q[4:0] == 5'h01 && date_q[7:6] == $past(yr) + 2'd1));
    assert_wday_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_month_i && wd == 3'd6) |=> (month_q[7:5] == 3'd0));
endmodule

// File: rtl/ccc_top.sv
// Clock-calendar counter chain: three BCD pairs, hours, two calendar bytes.
// Steps once per tick_i unless halted; in pulse mode only the pairs count.
// Assumes the control inputs come from a control register outside the block.
module ccc_top
    import ccc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              evt_mode_i,
    input  logic              halt_i,
    input  logic              mask_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(PAIRS + 1);
    localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(PAIRS + 2);
    localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(PAIRS + 3);

    logic [PAIRS:0] chain;
    bcd8_t          pair_val [PAIRS];
    logic           hour_step, day_step;
    bcd8_t          hour_val, date_val, month_val;

    assign chain[0] = tick_i && !halt_i;

    // Repeated BCD pair stages: hundredths, seconds, minutes
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        ccc_pair_cnt #(
            .CLK_LAST((g == 0) ? 8'h99 : 8'h59)
        ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_i  (chain[g]),
            .evt_i   (evt_mode_i),
            .wr_i    (wr_en_i && (wr_addr_i == ADDR_W'(g + 1))),
            .wdata_i (wr_data_i),
            .value_o (pair_val[g]),
            .carry_o (chain[g+1])
        );
    end

    assign hour_step = chain[PAIRS] && !evt_mode_i;

    ccc_hour_cnt u_hour (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (hour_step),
        .wr_i    (wr_en_i && (wr_addr_i == A_HOUR)),
        .wdata_i (wr_data_i),
        .value_o (hour_val),
        .carry_o (day_step)
    );

    ccc_date_cnt u_date (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (day_step),
        .wr_date_i    (wr_en_i && (wr_addr_i == A_DATE)),
        .wr_month_i   (wr_en_i && (wr_addr_i == A_MONTH)),
        .wdata_i      (wr_data_i),
        .date_byte_o  (date_val),
        .month_byte_o (month_val)
    );

    // Read multiplexer with optional masking of year and weekday
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i >= ADDR_W'(1) && rd_addr_i <= ADDR_W'(PAIRS))
            rd_data_o = pair_val[rd_addr_i - ADDR_W'(1)];
        else if (rd_addr_i == A_HOUR)
            rd_data_o = hour_val;
        else if (rd_addr_i == A_DATE)
            rd_data_o = mask_i ? {2'b00, date_val[5:0]} : date_val;
        else if (rd_addr_i == A_MONTH)
            rd_data_o = mask_i ? {3'b000, month_val[4:0]} : month_val;
    end

    assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !wr_en_i) |=> ($stable(hour_val) && $stable(date_val) && $stable(month_val)
                                  && $stable(pair_val[0]) && $stable(pair_val[PAIRS-1])));
    assert_evt_calendar_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mode_i && !wr_en_i) |=> ($stable(hour_val) && $stable(date_val) && $stable(month_val)));
    assert_mask_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && rd_addr_i == A_DATE) |-> (rd_data_o[7:6] == 2'b00 && rd_data_o[5:0] == date_val[5:0]));
    assert_outside_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == '0 || rd_addr_i > A_MONTH) |-> (rd_data_o == 8'h00));
endmodule

// File: tb/tb_ccc_top.sv
// Bench: behavioural integer reference updated each edge, all addresses compared each cycle.
module tb_ccc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, evt_mode_i = 1'b0, halt_i = 1'b0, mask_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [3:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;

    int    n_vec = 0, n_bad = 0, cyc = 0;
    string phase = "R11";
    logic [7:0] mr [0:7];

    ccc_top #(.ADDR_W(4)) dut (.*);

    always #10 clk = ~clk;

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Reference model of all registers
    always @(posedge clk) begin
        logic [7:0] nx [0:7];
        nx = mr;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) nx[i] = 8'h00;
        end else begin
            if (tick_i && !halt_i) begin
                if (evt_mode_i) begin
                    int tot;
                    tot = (b2i(mr[3]) * 10000 + b2i(mr[2]) * 100 + b2i(mr[1]) + 1) % 1000000;
                    nx[1] = i2b(tot % 100); nx[2] = i2b((tot / 100) % 100); nx[3] = i2b(tot / 10000);
                end else begin
                    int hs, sc, mn, idx, d, mon, yr, wd, dim;
                    bit hc, dc;
                    hs = b2i(mr[1]) + 1; sc = b2i(mr[2]); mn = b2i(mr[3]); hc = 0; dc = 0;
                    if (hs == 100) begin hs = 0; sc++; end
                    if (sc == 60) begin sc = 0; mn++; end
                    if (mn == 60) begin mn = 0; hc = 1; end
                    nx[1] = i2b(hs); nx[2] = i2b(sc); nx[3] = i2b(mn);
                    if (hc) begin
                        if (mr[4][7]) idx = (b2i({2'b0, mr[4][5:0]}) % 12) + (mr[4][6] ? 12 : 0);
                        else          idx = b2i({2'b0, mr[4][5:0]});
                        idx++;
                        if (idx == 24) begin idx = 0; dc = 1; end
                        if (mr[4][7]) nx[4] = {1'b1, idx >= 12, i2b((idx % 12 == 0) ? 12 : idx % 12)[5:0]};
                        else          nx[4] = {mr[4][7:6], i2b(idx)[5:0]};
                    end
                    if (dc) begin
                        yr = mr[5][7:6]; d = b2i({2'b0, mr[5][5:0]});
                        wd = mr[6][7:5]; mon = b2i({3'b0, mr[6][4:0]});
                        if (mon == 2) dim = (yr == 0) ? 29 : 28;
                        else if (mon == 4 || mon == 6 || mon == 9 || mon == 11) dim = 30;
                        else dim = 31;
                        wd = (wd + 1) % 7; d++;
                        if (d > dim) begin
                            d = 1; mon++;
                            if (mon > 12) begin mon = 1; yr = (yr + 1) % 4; end
                        end
                        nx[5] = {2'(yr), i2b(d)[5:0]};
                        nx[6] = {3'(wd), i2b(mon)[4:0]};
                    end
                end
            end
            if (wr_en_i && wr_addr_i >= 1 && wr_addr_i <= 6) nx[wr_addr_i] = wr_data_i;
        end
        mr = nx;
    end

    // Sweep every read address after each edge and compare with the model
    always @(posedge clk) begin
        #1;
        for (int a = 0; a < 8; a++) begin
            logic [7:0] exp;
            rd_addr_i = 4'(a);
            #1;
            exp = mr[a];
            if (mask_i && a == 5) exp = {2'b00, mr[5][5:0]};
            if (mask_i && a == 6) exp = {3'b000, mr[6][4:0]};
            n_vec++;
            if (rd_data_o !== exp) begin
                n_bad++;
                $display("FAIL %s addr %0d: actual %h expected %h (cycle %0d)", phase, a, rd_data_o, exp, cyc);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    // Load a full time under halt (R8), then release
    task automatic load(input logic [7:0] hs, sc, mn, hr, db, mb);
        @(negedge clk); halt_i = 1'b1;
        wr(1, hs); wr(2, sc); wr(3, mn); wr(4, hr); wr(5, db); wr(6, mb);
        @(negedge clk); halt_i = 1'b0;
    endtask

    initial begin
        phase = "R11"; repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        wr(0, 8'h55); wr(7, 8'hAA);                      // R11: ignored
        phase = "R1";  ticks(6200);                      // R1: pairs roll
        phase = "R8";  load(8'h99, 8'h10, 8'h20, 8'h05, 8'h44, 8'h23);
        @(negedge clk); tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 4'd2; wr_data_i = 8'h30;
        @(negedge clk); tick_i = 1'b0; wr_en_i = 1'b0;   // R8: write beats carry
        phase = "R5";  load(8'h99, 8'h59, 8'h59, 8'h23, 8'h68, 8'h02); ticks(3);  // yr1 Feb28
        load(8'h99, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02); ticks(3);  // yr0 Feb28 -> 29
        load(8'h99, 8'h59, 8'h59, 8'h23, 8'h29, 8'h02); ticks(3);  // yr0 Feb29 -> Mar1
        phase = "R2";  load(8'h90, 8'h59, 8'h59, 8'h22, 8'h15, 8'h07); ticks(120);
        phase = "R4";  load(8'h99, 8'h59, 8'h59, 8'h23, 8'h30, 8'h04); ticks(3);
        load(8'h99, 8'h59, 8'h59, 8'h23, 8'h30, 8'h08); ticks(3);
        load(8'h99, 8'h59, 8'h59, 8'h23, 8'h31, 8'h10); ticks(3);
        phase = "R6";  load(8'h99, 8'h59, 8'h59, 8'h23, 8'hF1, 8'hD2); ticks(3);
        phase = "R3";  load(8'h99, 8'h59, 8'h59, 8'h91, 8'h09, 8'h03); ticks(3);   // 11AM -> 12PM
        load(8'h99, 8'h59, 8'h59, 8'hD1, 8'h31, 8'h12); ticks(3);   // 11PM -> 12AM + day
        load(8'h99, 8'h59, 8'h59, 8'h92, 8'h05, 8'h05); ticks(3);   // 12AM -> 01AM
        phase = "R9";  mask_i = 1'b1; load(8'h00, 8'h00, 8'h00, 8'h00, 8'hD7, 8'hA9); ticks(4);
        mask_i = 1'b0; ticks(2);
        phase = "R7";  @(negedge clk); halt_i = 1'b1; ticks(50);
        @(negedge clk); halt_i = 1'b0;
        phase = "R10"; @(negedge clk); evt_mode_i = 1'b1;
        load(8'h97, 8'h99, 8'h99, 8'h13, 8'h44, 8'h45); ticks(5);
        load(8'h98, 8'h09, 8'h00, 8'h13, 8'h44, 8'h45); ticks(1300);
        @(negedge clk); evt_mode_i = 1'b0;
        phase = "R11"; @(negedge clk); rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule